// File: doc/BRIEF.md
# Secured Configuration Store with Signature

This block keeps the configuration image of a small programmable logic array and gives a device programmer a single-bit read/write port into it. The image holds eight output-polarity bits, eight input/output-select bits, sixty-four product-term-disable bits, two global mode bits, a 64-bit user signature, and a security bit. One flat bit address selects any cell. The block decodes that address into the field and the bit index.

A programming session starts with a start pulse. The block first erases the whole image, including the security bit, over a fixed number of cycles. It then opens a window in which writes take effect. An end pulse closes the window and loads a 16-bit checksum of the image, and that checksum covers the signature. When the security bit is set, reads of functional bits come back as zero and raise an error flag. The signature and the security bit stay readable at all times.

Top module: `cfg_store`

## Requirements
- R1: After reset, rvalid_o, rdata_o, rd_err_o and busy_o are 0, checksum_o is 0, and every cell reads back 0.
- R2: Bit addresses map as follows: polarity cell i at 2560+i, signature bit i at 2568+i, select cell i at 2632+i, product-term-disable bit i at 2640+i, the first global mode bit at 2704, the second at 2705, and security at 2706. Any other address reads 0 with no error, and a write to it changes nothing.
- R3: A read is accepted when req_i=1, we_i=0 and busy_o=0. rvalid_o and rdata_o are driven for exactly one cycle, one cycle after the request.
- R4: While the security bit is 1, a read of a functional bit (polarity, select, product-term-disable or global mode) returns rdata_o=0 with rd_err_o=1 in its single valid cycle.
- R5: Signature bits and the security bit can always be read without error, whatever the value of the security bit.
- R6: A prog_start_i pulse seen while busy_o=0 clears every cell, including security. busy_o is then high for exactly ERASE_CYCLES cycles, starting the cycle after the pulse, and the programming window opens after that.
- R7: A write (req_i=1, we_i=1) stores wdata_i only inside the programming window. Writes while busy or outside any session have no effect.
- R8: Read requests made while busy_o=1 are dropped, and rvalid_o stays 0.
- R9: A prog_end_i pulse inside the window closes it, and one cycle later checksum_o equals the 16-bit sum of 19 bytes. These are: the polarity byte; the select byte; eight product-term-disable bytes; the byte {6'b0, bit 2705, bit 2704}; and eight signature bytes. Byte j of a field holds its bits 8j..8j+7, with the lowest address in bit 0. The security bit is not included. checksum_o changes at no other time.
- R10: prog_end_i outside the window and prog_start_i while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_start_i | input | 1 | Begin a session: erase, then open the write window |
| prog_end_i | input | 1 | Close the write window and refresh the checksum |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Flat bit address |
| wdata_i | input | 1 | Write bit |
| rvalid_o | output | 1 | Read result valid |
| rdata_o | output | 1 | Read bit |
| rd_err_o | output | 1 | Read denied by security |
| busy_o | output | 1 | Erase in progress |
| checksum_o | output | CSUM_W | Image checksum |

## Verification
Read results, including rd_err_o, are due one clock after the request. busy_o rises one clock after an accepted start and falls ERASE_CYCLES clocks later. checksum_o moves one clock after an accepted end pulse. A behavioural model in the bench updates its expected values on each rising edge, using the inputs the bench drove on the preceding falling edge. Every output is then compared on the next falling edge, so each result is checked exactly in the cycle it is due.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  localparam int unsigned POL_BASE = 2560;
  localparam int unsigned SIG_BASE = 2568;
  localparam int unsigned AC1_BASE = 2632;
  localparam int unsigned PTD_BASE = 2640;
  localparam int unsigned SYN_ADDR = 2704;
  localparam int unsigned AC0_ADDR = 2705;
  localparam int unsigned SEC_ADDR = 2706;
  localparam int unsigned N_CELLS  = 8;
  localparam int unsigned SIG_BITS = 64;
  localparam int unsigned PTD_BITS = 64;
  localparam int unsigned IDX_W    = 6;

  typedef enum logic [2:0] {
    FLD_NONE, FLD_POL, FLD_SIG, FLD_AC1, FLD_PTD, FLD_SYN, FLD_AC0, FLD_SEC
  } fld_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_PROG} seq_e;
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
  import cfg_store_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output fld_e              fld_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              func_o
);
  logic [31:0] a;
  assign a = 32'(addr_i);

  always_comb begin
    fld_o = FLD_NONE;
    idx_o = '0;
    if (a >= POL_BASE && a < POL_BASE + N_CELLS) begin
      fld_o = FLD_POL; idx_o = IDX_W'(a - POL_BASE);
    end else if (a >= SIG_BASE && a < SIG_BASE + SIG_BITS) begin
      fld_o = FLD_SIG; idx_o = IDX_W'(a - SIG_BASE);
    end else if (a >= AC1_BASE && a < AC1_BASE + N_CELLS) begin
      fld_o = FLD_AC1; idx_o = IDX_W'(a - AC1_BASE);
    end else if (a >= PTD_BASE && a < PTD_BASE + PTD_BITS) begin
      fld_o = FLD_PTD; idx_o = IDX_W'(a - PTD_BASE);
    end else if (a == SYN_ADDR) begin
      fld_o = FLD_SYN;
    end else if (a == AC0_ADDR) begin
      fld_o = FLD_AC0;
    end else if (a == SEC_ADDR) begin
      fld_o = FLD_SEC;
    end
  end

  assign func_o = fld_o inside {FLD_POL, FLD_AC1, FLD_PTD, FLD_SYN, FLD_AC0};
endmodule

// File: rtl/cfg_cell_array.sv
module cfg_cell_array
  import cfg_store_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                we_i,
  input  fld_e                fld_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                wbit_i,
  output logic [N_CELLS-1:0]  pol_o,
  output logic [N_CELLS-1:0]  ac1_o,
  output logic [PTD_BITS-1:0] ptd_o,
  output logic                syn_o,
  output logic                ac0_o,
  output logic [SIG_BITS-1:0] sig_o,
  output logic                sec_o,
  output logic                rbit_o
);
  localparam int unsigned CELL_IW = $clog2(N_CELLS);
  logic [CELL_IW-1:0] cidx;
  assign cidx = idx_i[CELL_IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_o <= '0; ac1_o <= '0; ptd_o <= '0; sig_o <= '0;
      syn_o <= 1'b0; ac0_o <= 1'b0; sec_o <= 1'b0;
    end else if (clr_i) begin
      pol_o <= '0; ac1_o <= '0; ptd_o <= '0; sig_o <= '0;
      syn_o <= 1'b0; ac0_o <= 1'b0; sec_o <= 1'b0;
    end else if (we_i) begin
      unique case (fld_i)
        FLD_POL: pol_o[cidx]  <= wbit_i;
        FLD_AC1: ac1_o[cidx]  <= wbit_i;
        FLD_PTD: ptd_o[idx_i] <= wbit_i;
        FLD_SIG: sig_o[idx_i] <= wbit_i;
        FLD_SYN: syn_o        <= wbit_i;
        FLD_AC0: ac0_o        <= wbit_i;
        FLD_SEC: sec_o        <= wbit_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (fld_i)
      FLD_POL: rbit_o = pol_o[cidx];
      FLD_AC1: rbit_o = ac1_o[cidx];
      FLD_PTD: rbit_o = ptd_o[idx_i];
      FLD_SIG: rbit_o = sig_o[idx_i];
      FLD_SYN: rbit_o = syn_o;
      FLD_AC0: rbit_o = ac0_o;
      FLD_SEC: rbit_o = sec_o;
      default: rbit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_checksum.sv
module cfg_checksum
  import cfg_store_pkg::*;
#(
  parameter int unsigned CSUM_W = 16
) (
  input  logic [N_CELLS-1:0]  pol_i,
  input  logic [N_CELLS-1:0]  ac1_i,
  input  logic [PTD_BITS-1:0] ptd_i,
  input  logic                syn_i,
  input  logic                ac0_i,
  input  logic [SIG_BITS-1:0] sig_i,
  output logic [CSUM_W-1:0]   sum_o
);
  localparam int unsigned PTD_BYTES = PTD_BITS / 8;
  localparam int unsigned SIG_BYTES = SIG_BITS / 8;
  localparam int unsigned N_BYTES   = 3 + PTD_BYTES + SIG_BYTES;

  logic [7:0] bytes [N_BYTES];

  assign bytes[0] = pol_i;
  assign bytes[1] = ac1_i;
  assign bytes[2] = {6'b0, ac0_i, syn_i};

  for (genvar j = 0; j < PTD_BYTES; j++) begin : g_ptd
    assign bytes[3 + j] = ptd_i[8*j +: 8];
  end
  for (genvar j = 0; j < SIG_BYTES; j++) begin : g_sig
    assign bytes[3 + PTD_BYTES + j] = sig_i[8*j +: 8];
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < N_BYTES; k++) sum_o = sum_o + CSUM_W'(bytes[k]);
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_store_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic end_i,
  output logic busy_o,
  output logic prog_o,
  output logic clr_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(ERASE_CYCLES + 1);

  seq_e             st_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (st_q == ST_ERASE);
  assign prog_o = (st_q == ST_PROG);
  assign clr_o  = start_i && !busy_o;
  assign done_o = end_i && prog_o && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (clr_o) begin
      st_q  <= ST_ERASE;
      cnt_q <= '0;
    end else if (busy_o) begin
      if (cnt_q == CNT_W'(ERASE_CYCLES - 1)) st_q <= ST_PROG;
      else cnt_q <= cnt_q + 1'b1;
    end else if (done_o) begin
      st_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_store_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned ERASE_CYCLES = 16,
  parameter int unsigned CSUM_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_start_i,
  input  logic              prog_end_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  output logic              rvalid_o,
  output logic              rdata_o,
  output logic              rd_err_o,
  output logic              busy_o,
  output logic [CSUM_W-1:0] checksum_o
);
  fld_e               fld;
  logic [IDX_W-1:0]   idx;
  logic               func, rbit, prog, clr, done;
  logic [N_CELLS-1:0]  pol, ac1;
  logic [PTD_BITS-1:0] ptd;
  logic [SIG_BITS-1:0] sig;
  logic                syn, ac0, sec;
  logic [CSUM_W-1:0]   sum;

  cfg_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .fld_o(fld), .idx_o(idx), .func_o(func)
  );

  cfg_seq #(.ERASE_CYCLES(ERASE_CYCLES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(prog_start_i), .end_i(prog_end_i),
    .busy_o(busy_o), .prog_o(prog), .clr_o(clr), .done_o(done)
  );

  cfg_cell_array u_cells (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .we_i(req_i && we_i && prog), .fld_i(fld), .idx_i(idx), .wbit_i(wdata_i),
    .pol_o(pol), .ac1_o(ac1), .ptd_o(ptd), .syn_o(syn), .ac0_o(ac0),
    .sig_o(sig), .sec_o(sec), .rbit_o(rbit)
  );

  cfg_checksum #(.CSUM_W(CSUM_W)) u_sum (
    .pol_i(pol), .ac1_i(ac1), .ptd_i(ptd), .syn_i(syn), .ac0_i(ac0),
    .sig_i(sig), .sum_o(sum)
  );

  logic rd_acc, deny;
  assign rd_acc = req_i && !we_i && !busy_o;
  assign deny   = sec && func;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= 1'b0;
      rd_err_o <= 1'b0;
    end else begin
      rvalid_o <= rd_acc;
      rdata_o  <= rd_acc && !deny && rbit;
      rd_err_o <= rd_acc && deny;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   checksum_o <= '0;
    else if (done) checksum_o <= sum;
  end
endmodule

// File: rtl/cfg_store_chk.sv
module cfg_store_chk
  import cfg_store_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned ERASE_CYCLES = 16,
  parameter int unsigned CSUM_W       = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prog_start_i,
  input logic              prog_end_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rvalid_o,
  input logic              rdata_o,
  input logic              rd_err_o,
  input logic              busy_o,
  input logic [CSUM_W-1:0] checksum_o
);
  localparam int unsigned RUN_W = $clog2(ERASE_CYCLES + 2);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  p_err_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> (rvalid_o && !rdata_o));

  p_sig_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !busy_o && 32'(addr_i) >= SIG_BASE &&
     32'(addr_i) < SIG_BASE + SIG_BITS) |=> (rvalid_o && !rd_err_o));

  p_start_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_start_i && !busy_o) |=> busy_o);

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < RUN_W'(ERASE_CYCLES)));

  p_busy_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !rvalid_o);

  p_sum_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_end_i |=> $stable(checksum_o));
endmodule

bind cfg_store cfg_store_chk #(
  .ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES), .CSUM_W(CSUM_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .prog_start_i(prog_start_i),
  .prog_end_i(prog_end_i), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rvalid_o(rvalid_o), .rdata_o(rdata_o), .rd_err_o(rd_err_o),
  .busy_o(busy_o), .checksum_o(checksum_o)
);

// File: tb/cfg_store_test.sv
module cfg_store_test;
  localparam int AW = 12;
  localparam int EC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_start = 0, prog_end = 0, req = 0, we = 0, wdata = 0;
  logic [AW-1:0] addr = '0;
  logic rvalid, rdata, rd_err, busy;
  logic [15:0] csum;

  always #2.5 clk = ~clk;

  cfg_store #(.ADDR_W(AW), .ERASE_CYCLES(EC), .CSUM_W(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .prog_start_i(prog_start), .prog_end_i(prog_end),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata), .rd_err_o(rd_err), .busy_o(busy),
    .checksum_o(csum)
  );

  int vectors = 0, errors = 0, cycles = 0;
  string tag = "R1";
  bit done = 0;

  // reference model
  bit mem [4096];
  int mode = 0;  // 0 idle, 1 erasing, 2 window
  int left = 0;
  bit e_rvalid, e_rdata, e_err, e_busy;
  int e_csum;

  function automatic bit mapped(int a);
    return a >= 2560 && a <= 2706;
  endfunction
  function automatic bit functional(int a);
    return mapped(a) && !(a >= 2568 && a <= 2631) && a != 2706;
  endfunction
  function automatic int byte_at(int base);
    int v = 0;
    for (int k = 0; k < 8; k++) v += int'(mem[base + k]) << k;
    return v;
  endfunction
  function automatic int ref_sum();
    int s = byte_at(2560) + byte_at(2632) + int'(mem[2704]) + 2 * int'(mem[2705]);
    for (int j = 0; j < 8; j++) s += byte_at(2640 + 8 * j) + byte_at(2568 + 8 * j);
    return s % 65536;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mem[i]) mem[i] = 0;
      mode = 0; left = 0;
      e_rvalid = 0; e_rdata = 0; e_err = 0; e_busy = 0; e_csum = 0;
    end else begin
      e_rvalid = 0; e_rdata = 0; e_err = 0;
      if (mode != 1 && req && !we) begin
        e_rvalid = 1;
        if (mem[2706] && functional(int'(addr))) e_err = 1;
        else e_rdata = mem[int'(addr)];
      end
      if (mode == 2 && req && we && mapped(int'(addr))) mem[int'(addr)] = wdata;
      if (prog_start && mode != 1) begin
        foreach (mem[i]) mem[i] = 0;
        mode = 1; left = EC;
      end else if (mode == 1) begin
        left--;
        if (left == 0) mode = 2;
      end else if (mode == 2 && prog_end) begin
        e_csum = ref_sum();
        mode = 0;
      end
      e_busy = (mode == 1);
    end
  end

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      cmp("rvalid_o", int'(rvalid), int'(e_rvalid));
      cmp("rdata_o", int'(rdata), int'(e_rdata));
      cmp("rd_err_o", int'(rd_err), int'(e_err));
      cmp("busy_o", int'(busy), int'(e_busy));
      cmp("checksum_o", int'(csum), e_csum);
    end
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic idle(int n = 1);
    repeat (n) begin
      @(negedge clk);
      req = 0; we = 0; prog_start = 0; prog_end = 0;
    end
  endtask
  task automatic rd(int a);
    @(negedge clk);
    req = 1; we = 0; addr = AW'(a); prog_start = 0; prog_end = 0;
  endtask
  task automatic wr(int a, bit d);
    @(negedge clk);
    req = 1; we = 1; addr = AW'(a); wdata = d; prog_start = 0; prog_end = 0;
  endtask
  task automatic start_s();
    @(negedge clk);
    req = 0; prog_start = 1; prog_end = 0;
  endtask
  task automatic end_s();
    @(negedge clk);
    req = 0; prog_start = 0; prog_end = 1;
  endtask
  task automatic sweep();
    for (int a = 2556; a <= 2710; a++) rd(a);
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; sweep(); rd(100);
    tag = "R7"; wr(2560, 1); wr(2570, 1); rd(2560); rd(2570); idle(2);
    tag = "R6"; start_s();
    tag = "R8"; rd(2560); rd(2568);
    tag = "R7"; wr(2561, 1); wr(2600, 1);
    tag = "R10"; start_s(); end_s(); idle(EC);
    tag = "R7"; rd(2561); rd(2600); idle(1);
    tag = "R2";
    for (int i = 0; i < 8; i++) wr(2560 + i, (i % 3) == 0);
    for (int i = 0; i < 8; i++) wr(2632 + i, (i % 2) == 1);
    for (int i = 0; i < 64; i++) wr(2640 + i, ((i * 7) % 5) < 2);
    for (int i = 0; i < 64; i++) wr(2568 + i, ((i * 3) % 4) == 1);
    wr(2704, 1); wr(2705, 1); wr(2705, 0); wr(2705, 1);
    wr(2559, 1); wr(2707, 1); wr(5, 1); wr(4095, 1);
    sweep(); rd(5); rd(4095); idle(1);
    tag = "R9"; end_s(); idle(3);
    tag = "R10"; end_s(); wr(2561, 0); idle(2); rd(2561); idle(2);
    tag = "R9"; start_s(); idle(EC + 1);
    for (int i = 0; i < 64; i += 5) wr(2568 + i, 1);
    end_s(); idle(3);
    tag = "R4"; start_s(); idle(EC + 1);
    for (int i = 0; i < 8; i++) wr(2560 + i, 1);
    for (int i = 0; i < 64; i += 3) wr(2640 + i, 1);
    wr(2704, 1); wr(2570, 1); wr(2631, 1);
    wr(2706, 1); sweep();
    end_s(); idle(2);
    tag = "R5"; rd(2568); rd(2570); rd(2631); rd(2706); rd(2560); rd(2704); idle(2);
    tag = "R6"; start_s(); idle(EC + 1); sweep();
    tag = "R3"; rd(2570); idle(1); rd(2560); rd(2561); end_s(); idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule